// File: doc/BRIEF.md
# Fully Associative Translation Cache with Age-Based Replacement

This block holds a small set of recently used address mappings. A lookup compares the virtual page number against every stored entry at once. On a hit it returns the physical address, which is the cached physical page number joined to the untranslated offset, together with the cached entry. Each tag carries a privilege class bit (user or supervisor) and a process ID. Operating system mappings and the mappings of several processes can therefore share the table. An entry can map a small page of 4 KB or a large page of 4 MB.

After a miss, the surrounding logic fetches the mapping and writes it through the fill port. A fill goes to an entry that already holds the same mapping if there is one. Otherwise it goes to the lowest-numbered empty entry. Otherwise it replaces the least recently used entry. A change to either page table base register is signalled with a class invalidate, which clears every entry of that class in one cycle. A single page can be removed with a page invalidate.

Top module: `tlb_fa_lru`

## Requirements
- R1: While `rst` is high and in the cycle after it, `res_valid` and `res_hit` are 0 and every result field is 0. After reset no entry is valid, so every lookup misses until a fill is made.
- R2: The result of a lookup presented in cycle t appears on the outputs after the clock edge that ends cycle t. `res_valid` is 1 exactly when `lk_valid` was 1 in the previous cycle. On a miss, `res_hit`, `res_large`, `res_paddr`, `res_ppn` and `res_attr` are all 0.
- R3: A small-page hit returns `res_paddr = {ppn, vaddr[11:0]}`, together with the cached `res_ppn` and `res_attr` and with `res_large` = 0.
- R4: A hit requires the lookup class (`lk_super`, 1 = supervisor) to equal the class of the entry. A user entry also requires `lk_pid` to equal its stored ID. A supervisor entry matches under any `lk_pid`.
- R5: A large-page entry compares only `vaddr[31:22]`. It returns `res_paddr = {ppn[19:10], vaddr[21:0]}` with `res_large` = 1.
- R6: A fill goes to the first of these that applies. First, the lowest-numbered valid entry that a lookup of the fill's page, class and ID would hit; that entry is overwritten. Second, the lowest-numbered invalid entry. Third, the least recently used entry.
- R7: Recency is updated by every lookup hit and by every fill. In a cycle that has both, only the fill's entry is updated. Reset order treats the highest-numbered entry as the least recent.
- R8: A class invalidate (`inv_class_super` 1 = supervisor, 0 = user) clears every entry of that class, whatever its process ID, in one cycle. It leaves entries of the other class untouched.
- R9: A page invalidate clears every entry that a lookup of `inv_page_vpn` with the given class and ID would hit, including a large-page entry that covers it. It leaves all other entries untouched.
- R10: A lookup sees the table as it was before any fill or invalidate in the same cycle. A fill made in the same cycle as an invalidate is applied after the invalidate, so the filled entry stays valid.
- R11: When several entries match a lookup, the lowest-numbered one supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_super | input | 1 | Lookup class, 1 = supervisor |
| lk_pid | input | PID_W | Lookup process ID |
| fill_valid | input | 1 | Write a mapping |
| fill_vpn | input | VA_W-OFF_W | Virtual page number of the fill |
| fill_super | input | 1 | Class of the fill |
| fill_pid | input | PID_W | Process ID of the fill |
| fill_large | input | 1 | Fill maps a large page |
| fill_ppn | input | PA_W-OFF_W | Physical page number of the fill |
| fill_attr | input | ATTR_W | Cached entry flags |
| inv_class_valid | input | 1 | Clear every entry of one class |
| inv_class_super | input | 1 | Class to clear, 1 = supervisor |
| inv_page_valid | input | 1 | Clear the entries mapping one page |
| inv_page_vpn | input | VA_W-OFF_W | Page to clear |
| inv_page_super | input | 1 | Class of the page to clear |
| inv_page_pid | input | PID_W | Process ID of the page to clear |
| res_valid | output | 1 | A lookup result is present |
| res_hit | output | 1 | The lookup hit |
| res_large | output | 1 | The hit entry maps a large page |
| res_paddr | output | PA_W | Translated physical address |
| res_ppn | output | PA_W-OFF_W | Cached physical page number |
| res_attr | output | ATTR_W | Cached entry flags |

## Verification
The bench builds the block with four entries and keeps the default 32-bit address widths, 8-bit IDs and the 12-bit and 22-bit offsets. With only four entries the table fills after a handful of fills. Replacement by age is then reached quickly, and so are the choice between a duplicate, a free and a victim entry, and cases where one lookup matches two entries. A randomized phase draws from a small pool of pages, classes and IDs, so fills, invalidates and lookups often collide in the same cycle.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;
  localparam int DEF_ENTRIES = 16;
  localparam int DEF_VA_W    = 32;
  localparam int DEF_PA_W    = 32;
  localparam int DEF_OFF_W   = 12;
  localparam int DEF_BIG_W   = 22;
  localparam int DEF_PID_W   = 8;
  localparam int DEF_ATTR_W  = 4;

  // where a fill lands
  typedef enum logic [1:0] {
    SRC_DUP  = 2'd0,
    SRC_FREE = 2'd1,
    SRC_LRU  = 2'd2
  } fill_src_e;
endpackage

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int BIG_SH = 10,
  parameter int PID_W  = 8
) (
  input  logic             e_valid [N],
  input  logic [VPN_W-1:0] e_vpn   [N],
  input  logic             e_super [N],
  input  logic [PID_W-1:0] e_pid   [N],
  input  logic             e_large [N],
  input  logic [VPN_W-1:0] q_vpn,
  input  logic             q_super,
  input  logic [PID_W-1:0] q_pid,
  output logic [N-1:0]     hit_vec
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic class_ok;
    logic id_ok;
    logic page_ok;
    assign class_ok = (e_super[g] == q_super);
    assign id_ok    = e_super[g] || (e_pid[g] == q_pid);
    assign page_ok  = e_large[g]
                      ? (e_vpn[g][VPN_W-1:BIG_SH] == q_vpn[VPN_W-1:BIG_SH])
                      : (e_vpn[g] == q_vpn);
    assign hit_vec[g] = e_valid[g] && class_ok && id_ok && page_ok;
  end
endmodule

// File: rtl/tlb_age_lru.sv
module tlb_age_lru #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0] age [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx)      age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (age[i] == IDX_W'(N - 1)) victim_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_fa_lru.sv
module tlb_fa_lru
  import tlb_fa_pkg::*;
#(
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int VA_W    = DEF_VA_W,
  parameter int PA_W    = DEF_PA_W,
  parameter int OFF_W   = DEF_OFF_W,
  parameter int BIG_W   = DEF_BIG_W,
  parameter int PID_W   = DEF_PID_W,
  parameter int ATTR_W  = DEF_ATTR_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic                  lk_super,
  input  logic [PID_W-1:0]      lk_pid,
  input  logic                  fill_valid,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic                  fill_super,
  input  logic [PID_W-1:0]      fill_pid,
  input  logic                  fill_large,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic [ATTR_W-1:0]     fill_attr,
  input  logic                  inv_class_valid,
  input  logic                  inv_class_super,
  input  logic                  inv_page_valid,
  input  logic [VA_W-OFF_W-1:0] inv_page_vpn,
  input  logic                  inv_page_super,
  input  logic [PID_W-1:0]      inv_page_pid,
  output logic                  res_valid,
  output logic                  res_hit,
  output logic                  res_large,
  output logic [PA_W-1:0]       res_paddr,
  output logic [PA_W-OFF_W-1:0] res_ppn,
  output logic [ATTR_W-1:0]     res_attr
);
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int BIG_SH = BIG_W - OFF_W;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // entry storage
  logic             e_valid [ENTRIES];
  logic [VPN_W-1:0] e_vpn   [ENTRIES];
  logic             e_super [ENTRIES];
  logic [PID_W-1:0] e_pid   [ENTRIES];
  logic             e_large [ENTRIES];
  logic [PPN_W-1:0] e_ppn   [ENTRIES];
  logic [ATTR_W-1:0] e_attr [ENTRIES];

  logic [ENTRIES-1:0] lk_vec, dup_vec, pg_vec, free_vec, kill_vec;
  logic               lk_found, dup_found, free_found;
  logic [IDX_W-1:0]   lk_idx, dup_idx, free_idx, victim_idx, slot_idx;
  logic               touch;
  logic [IDX_W-1:0]   touch_idx;
  fill_src_e          fill_src;

  // three parallel comparator banks: lookup, fill duplicate, page invalidate
  tlb_tag_cmp #(.N(ENTRIES), .VPN_W(VPN_W), .BIG_SH(BIG_SH), .PID_W(PID_W)) u_cmp_lk (
    .e_valid(e_valid), .e_vpn(e_vpn), .e_super(e_super), .e_pid(e_pid), .e_large(e_large),
    .q_vpn(lk_vaddr[VA_W-1:OFF_W]), .q_super(lk_super), .q_pid(lk_pid), .hit_vec(lk_vec)
  );

  tlb_tag_cmp #(.N(ENTRIES), .VPN_W(VPN_W), .BIG_SH(BIG_SH), .PID_W(PID_W)) u_cmp_dup (
    .e_valid(e_valid), .e_vpn(e_vpn), .e_super(e_super), .e_pid(e_pid), .e_large(e_large),
    .q_vpn(fill_vpn), .q_super(fill_super), .q_pid(fill_pid), .hit_vec(dup_vec)
  );

  tlb_tag_cmp #(.N(ENTRIES), .VPN_W(VPN_W), .BIG_SH(BIG_SH), .PID_W(PID_W)) u_cmp_pg (
    .e_valid(e_valid), .e_vpn(e_vpn), .e_super(e_super), .e_pid(e_pid), .e_large(e_large),
    .q_vpn(inv_page_vpn), .q_super(inv_page_super), .q_pid(inv_page_pid), .hit_vec(pg_vec)
  );

  tlb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_lk (
    .vec(lk_vec), .found(lk_found), .idx(lk_idx)
  );

  tlb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_dup (
    .vec(dup_vec), .found(dup_found), .idx(dup_idx)
  );

  tlb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_free (
    .vec(free_vec), .found(free_found), .idx(free_idx)
  );

  tlb_age_lru #(.N(ENTRIES), .IDX_W(IDX_W)) u_age (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx), .victim_idx(victim_idx)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign free_vec[g] = !e_valid[g];
    assign kill_vec[g] = (inv_class_valid && e_valid[g] && (e_super[g] == inv_class_super))
                       || (inv_page_valid && pg_vec[g]);
  end

  // fill placement: duplicate, then free, then least recent
  always_comb begin
    if (dup_found) begin
      fill_src = SRC_DUP;
      slot_idx = dup_idx;
    end else if (free_found) begin
      fill_src = SRC_FREE;
      slot_idx = free_idx;
    end else begin
      fill_src = SRC_LRU;
      slot_idx = victim_idx;
    end
  end

  // a fill claims the recency update over a same-cycle hit
  assign touch     = fill_valid || (lk_valid && lk_found);
  assign touch_idx = fill_valid ? slot_idx : lk_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) e_valid[i] <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_valid && (slot_idx == IDX_W'(i))) begin
          e_valid[i] <= 1'b1;
        end else if (kill_vec[i]) begin
          e_valid[i] <= 1'b0;
        end
      end
    end
  end

  // payload carries no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_valid && (slot_idx == IDX_W'(i))) begin
        e_vpn[i]   <= fill_vpn;
        e_super[i] <= fill_super;
        e_pid[i]   <= fill_pid;
        e_large[i] <= fill_large;
        e_ppn[i]   <= fill_ppn;
        e_attr[i]  <= fill_attr;
      end
    end
  end

  // registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_large <= 1'b0;
      res_paddr <= '0;
      res_ppn   <= '0;
      res_attr  <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid && lk_found) begin
        res_hit   <= 1'b1;
        res_large <= e_large[lk_idx];
        res_ppn   <= e_ppn[lk_idx];
        res_attr  <= e_attr[lk_idx];
        if (e_large[lk_idx])
          res_paddr <= {e_ppn[lk_idx][PPN_W-1:BIG_SH], lk_vaddr[BIG_W-1:0]};
        else
          res_paddr <= {e_ppn[lk_idx], lk_vaddr[OFF_W-1:0]};
      end else begin
        res_hit   <= 1'b0;
        res_large <= 1'b0;
        res_ppn   <= '0;
        res_attr  <= '0;
        res_paddr <= '0;
      end
    end
  end
endmodule

// File: rtl/tlb_fa_lru_chk.sv
module tlb_fa_lru_chk #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int BIG_W = 22
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  lk_valid,
  input logic [BIG_W-1:0]      lk_low,
  input logic                  lk_super,
  input logic                  fill_valid,
  input logic                  inv_class_valid,
  input logic                  inv_class_super,
  input logic                  res_valid,
  input logic                  res_hit,
  input logic                  res_large,
  input logic [PA_W-1:0]       res_paddr,
  input logic [PA_W-OFF_W-1:0] res_ppn
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!res_valid && !res_hit));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);

  p_miss_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_paddr == '0 && !res_large));

  p_small_join_r3: assert property (@(posedge clk) disable iff (rst)
    (res_hit && !res_large) |->
      (res_paddr[PA_W-1:OFF_W] == res_ppn && res_paddr[OFF_W-1:0] == $past(lk_low[OFF_W-1:0])));

  p_large_offset_r5: assert property (@(posedge clk) disable iff (rst)
    (res_hit && res_large) |-> (res_paddr[BIG_W-1:0] == $past(lk_low)));

  p_class_flush_r8: assert property (@(posedge clk) disable iff (rst)
    (inv_class_valid && !fill_valid) ##1 (lk_valid && lk_super == $past(inv_class_super))
      |=> !res_hit);
endmodule

bind tlb_fa_lru tlb_fa_lru_chk #(.PA_W(PA_W), .OFF_W(OFF_W), .BIG_W(BIG_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_low(lk_vaddr[BIG_W-1:0]),
  .lk_super(lk_super), .fill_valid(fill_valid), .inv_class_valid(inv_class_valid),
  .inv_class_super(inv_class_super), .res_valid(res_valid), .res_hit(res_hit),
  .res_large(res_large), .res_paddr(res_paddr), .res_ppn(res_ppn)
);

// File: tb/sim_tlb_fa_lru.sv
`timescale 1ns/1ps
module sim_tlb_fa_lru;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 0, lk_super = 0;
  logic [31:0] lk_vaddr = 0;
  logic [7:0]  lk_pid = 0;
  logic        fill_valid = 0, fill_super = 0, fill_large = 0;
  logic [19:0] fill_vpn = 0, fill_ppn = 0;
  logic [7:0]  fill_pid = 0;
  logic [3:0]  fill_attr = 0;
  logic        inv_class_valid = 0, inv_class_super = 0;
  logic        inv_page_valid = 0, inv_page_super = 0;
  logic [19:0] inv_page_vpn = 0;
  logic [7:0]  inv_page_pid = 0;
  logic        res_valid, res_hit, res_large;
  logic [31:0] res_paddr;
  logic [19:0] res_ppn;
  logic [3:0]  res_attr;

  always #2 clk = ~clk;

  tlb_fa_lru #(.ENTRIES(N)) u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_super(lk_super),
    .lk_pid(lk_pid), .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_super(fill_super),
    .fill_pid(fill_pid), .fill_large(fill_large), .fill_ppn(fill_ppn), .fill_attr(fill_attr),
    .inv_class_valid(inv_class_valid), .inv_class_super(inv_class_super),
    .inv_page_valid(inv_page_valid), .inv_page_vpn(inv_page_vpn),
    .inv_page_super(inv_page_super), .inv_page_pid(inv_page_pid),
    .res_valid(res_valid), .res_hit(res_hit), .res_large(res_large),
    .res_paddr(res_paddr), .res_ppn(res_ppn), .res_attr(res_attr)
  );

  int    n_chk = 0, n_fail = 0;
  bit    armed = 0, done = 0;
  string cur_req = "R1";

  // behavioural reference: entry list plus a recency queue (front = newest)
  bit        mv [N];
  bit [19:0] mvpn [N];
  bit        ms [N];
  bit [7:0]  mp [N];
  bit        ml [N];
  bit [19:0] mppn [N];
  bit [3:0]  ma [N];
  int        recent [$];
  bit        x_valid, x_hit, x_large;
  bit [31:0] x_paddr;
  bit [19:0] x_ppn;
  bit [3:0]  x_attr;

  function automatic bit m_hits(int i, bit [19:0] vpn, bit sup, bit [7:0] pid);
    if (!mv[i] || ms[i] != sup) return 0;
    if (!sup && mp[i] != pid) return 0;
    if (ml[i]) return mvpn[i][19:10] == vpn[19:10];
    return mvpn[i] == vpn;
  endfunction

  function automatic void m_touch(int k);
    foreach (recent[j]) if (recent[j] == k) begin recent.delete(j); break; end
    recent.push_front(k);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
      recent = {};
      for (int i = 0; i < N; i++) recent.push_back(i);
      {x_valid, x_hit, x_large, x_paddr, x_ppn, x_attr} = '0;
    end else begin
      int lk, slot;
      bit kill [N];
      lk = -1;
      for (int i = N - 1; i >= 0; i--) if (m_hits(i, lk_vaddr[31:12], lk_super, lk_pid)) lk = i;
      x_valid = lk_valid;
      x_hit   = lk_valid && lk >= 0;
      if (x_hit) begin
        x_large = ml[lk]; x_ppn = mppn[lk]; x_attr = ma[lk];
        x_paddr = ml[lk] ? {mppn[lk][19:10], lk_vaddr[21:0]} : {mppn[lk], lk_vaddr[11:0]};
      end else begin
        {x_large, x_paddr, x_ppn, x_attr} = '0;
      end
      for (int i = 0; i < N; i++)
        kill[i] = (inv_class_valid && mv[i] && ms[i] == inv_class_super) ||
                  (inv_page_valid && m_hits(i, inv_page_vpn, inv_page_super, inv_page_pid));
      slot = -1;
      for (int i = N - 1; i >= 0; i--) if (m_hits(i, fill_vpn, fill_super, fill_pid)) slot = i;
      if (slot < 0) for (int i = N - 1; i >= 0; i--) if (!mv[i]) slot = i;
      if (slot < 0) slot = recent[$];
      if (fill_valid) m_touch(slot);
      else if (x_hit) m_touch(lk);
      for (int i = 0; i < N; i++) if (kill[i]) mv[i] = 0;
      if (fill_valid) begin
        mv[slot] = 1; mvpn[slot] = fill_vpn; ms[slot] = fill_super; mp[slot] = fill_pid;
        ml[slot] = fill_large; mppn[slot] = fill_ppn; ma[slot] = fill_attr;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      n_chk++;
      if (res_valid !== x_valid || res_hit !== x_hit || res_large !== x_large ||
          res_paddr !== x_paddr || res_ppn !== x_ppn || res_attr !== x_attr) begin
        n_fail++;
        $display("FAIL %s model: actual v=%b h=%b l=%b pa=%h ppn=%h at=%h expected v=%b h=%b l=%b pa=%h ppn=%h at=%h",
                 cur_req, res_valid, res_hit, res_large, res_paddr, res_ppn, res_attr,
                 x_valid, x_hit, x_large, x_paddr, x_ppn, x_attr);
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    lk_valid = 0; fill_valid = 0; inv_class_valid = 0; inv_page_valid = 0;
  endtask

  task automatic set_lk(logic [31:0] va, logic sup, logic [7:0] pid);
    lk_valid = 1; lk_vaddr = va; lk_super = sup; lk_pid = pid;
  endtask

  task automatic set_fill(logic [19:0] vpn, logic sup, logic [7:0] pid, logic lg,
                          logic [19:0] ppn, logic [3:0] at);
    fill_valid = 1; fill_vpn = vpn; fill_super = sup; fill_pid = pid;
    fill_large = lg; fill_ppn = ppn; fill_attr = at;
  endtask

  task automatic set_icls(logic sup);
    inv_class_valid = 1; inv_class_super = sup;
  endtask

  task automatic set_ipg(logic [19:0] vpn, logic sup, logic [7:0] pid);
    inv_page_valid = 1; inv_page_vpn = vpn; inv_page_super = sup; inv_page_pid = pid;
  endtask

  // apply what is set, return at the next falling edge with the result visible
  task automatic go();
    @(posedge clk);
    @(negedge clk);
    clr();
  endtask

  task automatic look(logic [31:0] va, logic sup, logic [7:0] pid);
    set_lk(va, sup, pid); go();
  endtask

  task automatic fill(logic [19:0] vpn, logic sup, logic [7:0] pid, logic lg,
                      logic [19:0] ppn, logic [3:0] at);
    set_fill(vpn, sup, pid, lg, ppn, at); go();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "res_valid in reset", {31'b0, res_valid}, 0);
    chk("R1", "res_paddr in reset", res_paddr, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "res_hit after reset", {31'b0, res_hit}, 0);
    armed = 1;

    // R1/R2: empty table misses
    cur_req = "R2";
    look(32'h0000_1234, 0, 8'd5);
    chk("R2", "valid after lookup", {31'b0, res_valid}, 1);
    chk("R1", "hit on empty table", {31'b0, res_hit}, 0);
    @(negedge clk);
    chk("R2", "valid without lookup", {31'b0, res_valid}, 0);

    // R3 small page
    cur_req = "R3";
    fill(20'h00003, 0, 8'd5, 0, 20'h000AB, 4'h3);
    look(32'h0000_3ABC, 0, 8'd5);
    chk("R3", "small hit", {31'b0, res_hit}, 1);
    chk("R3", "small paddr", res_paddr, 32'h000A_BABC);
    chk("R3", "small attr", {28'b0, res_attr}, 32'h3);

    // R4 class and id
    cur_req = "R4";
    look(32'h0000_3ABC, 0, 8'd6);
    chk("R4", "other pid misses", {31'b0, res_hit}, 0);
    look(32'h0000_3ABC, 1, 8'd5);
    chk("R4", "other class misses", {31'b0, res_hit}, 0);
    fill(20'h80000, 1, 8'd0, 0, 20'h12345, 4'h5);
    look(32'h8000_0FFF, 1, 8'h77);
    chk("R4", "supervisor any pid", res_paddr, 32'h1234_5FFF);

    // R5 large page
    cur_req = "R5";
    fill(20'h40000, 0, 8'd5, 1, 20'h3FC00, 4'h1);
    look(32'h403A_5678, 0, 8'd5);
    chk("R5", "large paddr", res_paddr, 32'h3FFA_5678);
    chk("R5", "large flag", {31'b0, res_large}, 1);
    look(32'h4040_0000, 0, 8'd5);
    chk("R5", "outside large page", {31'b0, res_hit}, 0);

    // R6 duplicate overwrite, then free slot
    cur_req = "R6";
    fill(20'h00003, 0, 8'd5, 0, 20'h000CD, 4'h2);
    look(32'h0000_3010, 0, 8'd5);
    chk("R6", "duplicate overwritten", res_paddr, 32'h000C_D010);
    fill(20'h00005, 0, 8'd5, 0, 20'h00055, 4'h0);

    // R7 eviction of the least recent (supervisor entry)
    cur_req = "R7";
    look(32'h4000_0000, 0, 8'd5);
    fill(20'h00007, 0, 8'd5, 0, 20'h00077, 4'h0);
    look(32'h8000_0000, 1, 8'd0);
    chk("R7", "least recent evicted", {31'b0, res_hit}, 0);
    look(32'h0000_7000, 0, 8'd5);
    chk("R7", "new entry present", {31'b0, res_hit}, 1);
    look(32'h0000_3000, 0, 8'd5);
    chk("R7", "recent entry kept", {31'b0, res_hit}, 1);

    // R8 class invalidate
    cur_req = "R8";
    fill(20'h90000, 1, 8'd0, 0, 20'h00099, 4'h0);
    set_icls(0); go();
    look(32'h0000_3000, 0, 8'd5);
    chk("R8", "user flushed", {31'b0, res_hit}, 0);
    look(32'h9000_0000, 1, 8'd0);
    chk("R8", "supervisor kept", {31'b0, res_hit}, 1);
    set_icls(1); go();
    look(32'h9000_0000, 1, 8'd0);
    chk("R8", "supervisor flushed", {31'b0, res_hit}, 0);

    // R9 page invalidate
    cur_req = "R9";
    fill(20'h00003, 0, 8'd5, 0, 20'h000AB, 4'h0);
    fill(20'h40000, 0, 8'd5, 1, 20'h3FC00, 4'h0);
    fill(20'h00003, 0, 8'd6, 0, 20'h00066, 4'h0);
    set_ipg(20'h00003, 0, 8'd5); go();
    look(32'h0000_3000, 0, 8'd5);
    chk("R9", "page removed", {31'b0, res_hit}, 0);
    look(32'h0000_3004, 0, 8'd6);
    chk("R9", "other pid kept", res_paddr, 32'h0006_6004);
    look(32'h4000_0000, 0, 8'd5);
    chk("R9", "large kept", {31'b0, res_hit}, 1);
    set_ipg(20'h40123, 0, 8'd5); go();
    look(32'h4000_0000, 0, 8'd5);
    chk("R9", "covering large removed", {31'b0, res_hit}, 0);

    // R10 same-cycle ordering
    cur_req = "R10";
    fill(20'h00008, 0, 8'd5, 0, 20'h00088, 4'h0);
    set_lk(32'h0000_8000, 0, 8'd5); set_icls(0); go();
    chk("R10", "lookup sees pre-flush", {31'b0, res_hit}, 1);
    look(32'h0000_8000, 0, 8'd5);
    chk("R10", "flushed afterwards", {31'b0, res_hit}, 0);
    set_icls(0); set_fill(20'h00009, 0, 8'd5, 0, 20'h00009, 4'h0); go();
    look(32'h0000_9000, 0, 8'd5);
    chk("R10", "fill survives flush", {31'b0, res_hit}, 1);

    // R11 overlapping entries
    cur_req = "R11";
    fill(20'h40001, 0, 8'd7, 0, 20'h00011, 4'h0);
    fill(20'h40000, 0, 8'd7, 1, 20'hFFC00, 4'h0);
    look(32'h4000_1234, 0, 8'd7);
    chk("R11", "lowest index wins", res_paddr, 32'h0001_1234);

    // randomized mix compared against the model
    cur_req = "R6,R7,R10";
    for (int c = 0; c < 4000; c++) begin
      bit [19:0] pool [7] = '{20'h00003, 20'h00005, 20'h40000, 20'h40123,
                              20'h80000, 20'h90000, 20'h00007};
      @(negedge clk);
      clr();
      if ($urandom_range(0, 1) == 0)
        set_lk({pool[$urandom_range(0, 6)], 12'($urandom)}, 1'($urandom), 8'($urandom_range(5, 6)));
      if ($urandom_range(0, 2) == 0)
        set_fill(pool[$urandom_range(0, 6)], 1'($urandom), 8'($urandom_range(5, 6)),
                 $urandom_range(0, 3) == 0, 20'($urandom), 4'($urandom));
      if ($urandom_range(0, 24) == 0) set_icls(1'($urandom));
      if ($urandom_range(0, 9) == 0)
        set_ipg(pool[$urandom_range(0, 6)], 1'($urandom), 8'($urandom_range(5, 6)));
    end
    @(negedge clk);
    clr();
    repeat (2) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule